// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to fifteen interrupt request lines, numbered 1 to 15. Each request is captured into a sticky pending bit. A request is captured either while the line is high or on its rising edge, chosen per source. A mask register decides which pending sources may reach the processor. In every cycle the block presents the highest-numbered pending source that is not masked. It gives this source as a 4-bit level and as an 8-bit trap type. The source number is the pending bit position, the level and the low nibble of the trap type.

Software reaches the block through a plain register bus. The bus carries an 8-bit byte address, a write strobe, 32-bit write data and combinational 32-bit read data. Pending bits are removed by writing ones to a clear register, or by the processor returning the serviced level on the acknowledge inputs. A force register injects requests for test purposes. It works only while an enable bit in a test-control register is set.

Top module: `vec_intc`

## Requirements
- R1: After reset every source is masked (mask reads 0x0000FFFE), nothing is pending, the shape and test-control registers read 0, and the level and trap outputs are 0.
- R2: With its shape bit at 0 a source is level-sensitive: a request that is high at a clock edge sets its pending bit, and the bit stays set after the request drops.
- R3: With its shape bit at 1 a source is edge-sensitive: only a low-to-high change of the request sets the pending bit, so a request held high does not set the bit again once it has been cleared.
- R4: A set mask bit keeps its source off the level output, but the source still latches into the pending register.
- R5: The level output is the highest source number n for which pending bit n is 1 and mask bit n is 0, or 0 when there is no such source.
- R6: The trap type is 0x10 plus the level while the level is non-zero, and 0x00 while the level is 0.
- R7: Writing the clear register (offset 0x50) removes each pending bit whose write-data bit is 1; pending bits written with 0 are left unchanged.
- R8: Writing the force register (offset 0x54) sets each pending bit whose write-data bit is 1, but only while bit 19 of the test-control register (offset 0xD0) is 1; otherwise the write has no effect.
- R9: While ack_valid is 1, the pending bit whose number equals ack_level is cleared at the next edge; an ack_level of 0 changes nothing.
- R10: When a source is captured in the same cycle that a clear write or an acknowledge removes it, the pending bit stays set.
- R11: Registers are at byte offsets shape 0x44, pending 0x48, mask 0x4C and test control 0xD0, and all of them read back through bus_rdata. Source n is bit n, bits 31:16 of the source registers read 0, and the clear and force offsets read 0. Test control holds all 32 bits.
- R12: Bit 0 of the shape, mask, clear and force registers is unused: it reads 0 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| req_in | input | 15 | Request lines, bit n is source n (index 15 down to 1) |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being serviced, clears that pending bit |
| irq_level | output | 4 | Winning source number, 0 when none |
| trap_type | output | 8 | Trap type of the winning source |

## Verification
The priority encoder is driven with a single request, with sparse groups of requests that mix high and low numbers, and with all fifteen at once. It is also driven with masks that hide the top bidder, that hide everything, and that leave only source 1 visible. This shows that the highest unmasked number wins, and that masking changes the output without changing what is pending. Edge and level capture are both given the same request held high across a clear. Only the edge-sensitive source stays cleared. Force is written once with the test enable off and once with it on. Clear writes and acknowledges are each made to coincide with a fresh capture, which shows that setting beats clearing.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

   localparam int unsigned BUS_ADDR_W = 8;
   localparam int unsigned BUS_DATA_W = 32;
   localparam int unsigned TRAP_W     = 8;

   // software-visible byte offsets
   localparam logic [BUS_ADDR_W-1:0] OFS_SHAPE = 8'h44;
   localparam logic [BUS_ADDR_W-1:0] OFS_PEND  = 8'h48;
   localparam logic [BUS_ADDR_W-1:0] OFS_MASK  = 8'h4C;
   localparam logic [BUS_ADDR_W-1:0] OFS_CLEAR = 8'h50;
   localparam logic [BUS_ADDR_W-1:0] OFS_FORCE = 8'h54;
   localparam logic [BUS_ADDR_W-1:0] OFS_TEST  = 8'hD0;

   // one-hot style write decode
   typedef struct packed {
      logic shape;
      logic mask;
      logic clear;
      logic force_set;
      logic test;
   } wr_dec_t;

endpackage

// File: rtl/vec_intc_capture.sv
module vec_intc_capture #(
   parameter int unsigned NUM_SRC = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC:1]   req_in,
   input  logic [NUM_SRC:1]   edge_sel,
   output logic [NUM_SRC:1]   hit
);

   logic [NUM_SRC:1] req_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= '0;
      else        req_prev <= req_in;
   end

   // per source: rising edge or plain level qualifies the request
   generate
      for (genvar n = 1; n <= NUM_SRC; n++) begin : g_src
         assign hit[n] = edge_sel[n] ? (req_in[n] & ~req_prev[n]) : req_in[n];
      end
   endgenerate

endmodule

// File: rtl/vec_intc_regs.sv
module vec_intc_regs
   import vec_intc_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 15,
   parameter int unsigned LVL_W       = 4,
   parameter int unsigned TEST_EN_BIT = 19
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BUS_ADDR_W-1:0]  bus_addr,
   input  logic                   bus_wr,
   input  logic [BUS_DATA_W-1:0]  bus_wdata,
   output logic [BUS_DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC:1]       hit,
   input  logic                   ack_valid,
   input  logic [LVL_W-1:0]       ack_level,
   output logic [NUM_SRC:1]       shape_q,
   output logic [NUM_SRC:1]       mask_q,
   output logic [NUM_SRC:1]       pend_q,
   output logic                   test_en
);

   localparam int unsigned PAD_W = BUS_DATA_W - NUM_SRC - 1;

   wr_dec_t                 dec;
   logic [BUS_DATA_W-1:0]   test_q;
   logic [NUM_SRC:1]        ack_hot;
   logic [NUM_SRC:1]        set_vec;
   logic [NUM_SRC:1]        clr_vec;
   logic [NUM_SRC:1]        wsrc;

   assign wsrc = bus_wdata[NUM_SRC:1];

   always_comb begin
      dec           = '0;
      dec.shape     = bus_wr && (bus_addr == OFS_SHAPE);
      dec.mask      = bus_wr && (bus_addr == OFS_MASK);
      dec.clear     = bus_wr && (bus_addr == OFS_CLEAR);
      dec.force_set = bus_wr && (bus_addr == OFS_FORCE);
      dec.test      = bus_wr && (bus_addr == OFS_TEST);
   end

   assign test_en = test_q[TEST_EN_BIT];

   generate
      for (genvar n = 1; n <= NUM_SRC; n++) begin : g_ack
         assign ack_hot[n] = ack_valid && (ack_level == LVL_W'(n));
      end
   endgenerate

   assign set_vec = hit | ((dec.force_set && test_en) ? wsrc : '0);
   assign clr_vec = ack_hot | (dec.clear ? wsrc : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shape_q <= '0;
         mask_q  <= '1;
         pend_q  <= '0;
         test_q  <= '0;
      end else begin
         if (dec.shape) shape_q <= wsrc;
         if (dec.mask)  mask_q  <= wsrc;
         if (dec.test)  test_q  <= bus_wdata;
         pend_q <= (pend_q & ~clr_vec) | set_vec;
      end
   end

   always_comb begin
      case (bus_addr)
         OFS_SHAPE: bus_rdata = {{PAD_W{1'b0}}, shape_q, 1'b0};
         OFS_PEND:  bus_rdata = {{PAD_W{1'b0}}, pend_q, 1'b0};
         OFS_MASK:  bus_rdata = {{PAD_W{1'b0}}, mask_q, 1'b0};
         OFS_TEST:  bus_rdata = test_q;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/vec_intc_prio.sv
module vec_intc_prio
   import vec_intc_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 15,
   parameter int unsigned LVL_W     = 4,
   parameter logic [TRAP_W-1:0] TRAP_BASE = 8'h10
) (
   input  logic [NUM_SRC:1]     active,
   output logic [LVL_W-1:0]     level,
   output logic [TRAP_W-1:0]    trap
);

   // ascending scan: the last qualifying (highest) source wins
   always_comb begin
      level = '0;
      for (int n = 1; n <= NUM_SRC; n++) begin
         if (active[n]) level = LVL_W'(n);
      end
   end

   assign trap = (level == '0) ? '0 : (TRAP_BASE + TRAP_W'(level));

endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import vec_intc_pkg::*;
#(
   parameter int unsigned       NUM_SRC     = 15,
   parameter int unsigned       TEST_EN_BIT = 19,
   parameter logic [TRAP_W-1:0] TRAP_BASE   = 8'h10,
   localparam int unsigned      LVL_W       = $clog2(NUM_SRC + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BUS_ADDR_W-1:0]  bus_addr,
   input  logic                   bus_wr,
   input  logic [BUS_DATA_W-1:0]  bus_wdata,
   output logic [BUS_DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC:1]       req_in,
   input  logic                   ack_valid,
   input  logic [LVL_W-1:0]       ack_level,
   output logic [LVL_W-1:0]       irq_level,
   output logic [TRAP_W-1:0]      trap_type
);

   generate
      if (NUM_SRC < 1 || NUM_SRC > 15) begin : g_bad_src
         $error("vec_intc: NUM_SRC must lie in 1..15");
      end
      if (TEST_EN_BIT >= BUS_DATA_W) begin : g_bad_test
         $error("vec_intc: TEST_EN_BIT outside the data word");
      end
      if (TRAP_BASE[3:0] != 4'h0) begin : g_bad_base
         $error("vec_intc: TRAP_BASE low nibble must be zero");
      end
   endgenerate

   logic [NUM_SRC:1] hit;
   logic [NUM_SRC:1] shape_q;
   logic [NUM_SRC:1] mask_q;
   logic [NUM_SRC:1] pend_q;
   logic             test_en;
   logic [NUM_SRC:0] pend_vec;
   logic [NUM_SRC:0] mask_vec;

   assign pend_vec = {pend_q, 1'b0};
   assign mask_vec = {mask_q, 1'b0};

   vec_intc_capture #(.NUM_SRC(NUM_SRC)) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_in   (req_in),
      .edge_sel (shape_q),
      .hit      (hit)
   );

   vec_intc_regs #(
      .NUM_SRC     (NUM_SRC),
      .LVL_W       (LVL_W),
      .TEST_EN_BIT (TEST_EN_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .hit       (hit),
      .ack_valid (ack_valid),
      .ack_level (ack_level),
      .shape_q   (shape_q),
      .mask_q    (mask_q),
      .pend_q    (pend_q),
      .test_en   (test_en)
   );

   vec_intc_prio #(
      .NUM_SRC   (NUM_SRC),
      .LVL_W     (LVL_W),
      .TRAP_BASE (TRAP_BASE)
   ) u_prio (
      .active (pend_q & ~mask_q),
      .level  (irq_level),
      .trap   (trap_type)
   );

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk
   import vec_intc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 15,
   parameter int unsigned LVL_W   = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [BUS_ADDR_W-1:0]  bus_addr,
   input logic                   bus_wr,
   input logic [BUS_DATA_W-1:0]  bus_wdata,
   input logic [NUM_SRC:1]       req_in,
   input logic                   ack_valid,
   input logic [LVL_W-1:0]       ack_level,
   input logic [LVL_W-1:0]       irq_level,
   input logic [TRAP_W-1:0]      trap_type,
   input logic [NUM_SRC:0]       pend_vec,
   input logic [NUM_SRC:0]       mask_vec,
   input logic                   test_en
);

   logic force_live;
   assign force_live = bus_wr && (bus_addr == OFS_FORCE) && test_en;

   // R5
   level_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> (pend_vec[irq_level] && !mask_vec[irq_level]));

   // R4
   level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_vec & ~mask_vec) == '0) |-> (irq_level == '0));

   // R6
   trap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level != '0) |-> (trap_type == (8'h10 | TRAP_W'(irq_level))));

   // R7
   clear_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CLEAR && req_in == '0)
      |=> ((pend_vec[NUM_SRC:1] & $past(bus_wdata[NUM_SRC:1])) == '0));

   // R8
   no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_in == '0 && !force_live) |=> ((pend_vec & ~$past(pend_vec)) == '0));

   // R9
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_level != '0 && req_in == '0 && !force_live)
      |=> !pend_vec[$past(ack_level)]);

endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .req_in    (req_in),
   .ack_valid (ack_valid),
   .ack_level (ack_level),
   .irq_level (irq_level),
   .trap_type (trap_type),
   .pend_vec  (pend_vec),
   .mask_vec  (mask_vec),
   .test_en   (test_en)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;

   localparam int CLK_PERIOD = 10;

   localparam logic [7:0] A_SHAPE = 8'h44;
   localparam logic [7:0] A_PEND  = 8'h48;
   localparam logic [7:0] A_MASK  = 8'h4C;
   localparam logic [7:0] A_CLEAR = 8'h50;
   localparam logic [7:0] A_FORCE = 8'h54;
   localparam logic [7:0] A_TEST  = 8'hD0;

   typedef struct packed {
      logic [15:0] mask;
      logic [15:0] req;
      logic [3:0]  lvl;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{16'h0000, 16'h0008, 4'd3},
      '{16'h0000, 16'h1084, 4'd12},
      '{16'h1000, 16'h1084, 4'd7},
      '{16'hFFFE, 16'h1084, 4'd0},
      '{16'h0000, 16'h8002, 4'd15},
      '{16'hFFFC, 16'hFFFE, 4'd1},
      '{16'h0000, 16'hFFFE, 4'd15},
      '{16'h0000, 16'h0000, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:1] req_in = '0;
   logic        ack_valid = 1'b0;
   logic [3:0]  ack_level = '0;
   logic [3:0]  irq_level;
   logic [7:0]  trap_type;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vec_intc u_vec_intc (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .req_in    (req_in),
      .ack_valid (ack_valid),
      .ack_level (ack_level),
      .irq_level (irq_level),
      .trap_type (trap_type)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, d, exp);
   endtask

   task automatic check_out(input string tag, input logic [3:0] lvl);
      check({tag, " level"}, 32'(irq_level), 32'(lvl));
      check({tag, " trap"}, 32'(trap_type), (lvl == 0) ? 32'h0 : 32'h10 + 32'(lvl));
   endtask

   // request lines high for exactly one clock edge
   task automatic pulse(input logic [15:0] r);
      req_in = r[15:1];
      @(negedge clk);
      req_in = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_reg("R1 mask reset", A_MASK, 32'h0000_FFFE);
      check_reg("R1 pend reset", A_PEND, 32'h0);
      check_reg("R1 shape reset", A_SHAPE, 32'h0);
      check_reg("R1 test reset", A_TEST, 32'h0);
      check_out("R1", 4'd0);

      // R2 R4 R5 R6 table walk
      for (int i = 0; i < NVEC; i++) begin
         wr(A_MASK, {16'h0, VECS[i].mask});
         pulse(VECS[i].req);
         @(negedge clk);
         check_reg($sformatf("R2 R4 vec%0d pend", i), A_PEND, {16'h0, VECS[i].req & 16'hFFFE});
         check_out($sformatf("R5 R6 vec%0d", i), VECS[i].lvl);
         wr(A_CLEAR, 32'h0000_FFFE);
         check_reg($sformatf("R7 vec%0d cleared", i), A_PEND, 32'h0);
      end

      // R11 R12 readback and unused bits
      wr(A_MASK, 32'h1234_5679);
      check_reg("R11 R12 mask readback", A_MASK, 32'h0000_5678);
      wr(A_SHAPE, 32'hFFFF_0001);
      check_reg("R12 shape bit0", A_SHAPE, 32'h0);
      wr(A_TEST, 32'hA5A5_0F0F);
      check_reg("R11 test readback", A_TEST, 32'hA5A5_0F0F);
      wr(A_TEST, 32'h0);
      check_reg("R11 clear reads 0", A_CLEAR, 32'h0);
      check_reg("R11 force reads 0", A_FORCE, 32'h0);
      wr(A_MASK, 32'h0);

      // R7 partial clear
      pulse(16'h00F0);
      wr(A_CLEAR, 32'h0000_0030);
      check_reg("R7 partial clear", A_PEND, 32'h0000_00C0);
      check_out("R7 after partial", 4'd7);
      wr(A_CLEAR, 32'hFFFE);

      // R8 force gated by test enable, R12 bit0 ignored
      wr(A_FORCE, 32'h0000_0100);
      check_reg("R8 force gated off", A_PEND, 32'h0);
      wr(A_TEST, 32'h0008_0000);
      wr(A_FORCE, 32'h0000_0101);
      check_reg("R8 R12 force enabled", A_PEND, 32'h0000_0100);
      check_out("R8 forced", 4'd8);
      wr(A_TEST, 32'h0);
      wr(A_CLEAR, 32'hFFFE);

      // R9 acknowledge
      pulse(16'h0120);
      ack_valid = 1'b1; ack_level = 4'd8;
      @(negedge clk);
      ack_valid = 1'b0;
      check_reg("R9 ack clears 8", A_PEND, 32'h0000_0020);
      check_out("R9 next winner", 4'd5);
      ack_valid = 1'b1; ack_level = 4'd0;
      @(negedge clk);
      ack_valid = 1'b0;
      check_reg("R9 ack level 0 no effect", A_PEND, 32'h0000_0020);

      // R10 capture beats acknowledge
      req_in[5] = 1'b1;
      ack_valid = 1'b1; ack_level = 4'd5;
      @(negedge clk);
      ack_valid = 1'b0;
      check_reg("R10 set beats ack", A_PEND, 32'h0000_0020);
      // R10 capture beats clear write (level mode, held high)
      wr(A_CLEAR, 32'h0000_0020);
      check_reg("R10 set beats clear", A_PEND, 32'h0000_0020);
      req_in = '0;
      wr(A_CLEAR, 32'hFFFE);
      check_reg("R10 released then cleared", A_PEND, 32'h0);

      // R3 edge mode on source 6
      wr(A_SHAPE, 32'h0000_0040);
      req_in[6] = 1'b1;
      @(negedge clk);
      check_reg("R3 rising edge sets", A_PEND, 32'h0000_0040);
      wr(A_CLEAR, 32'h0000_0040);
      check_reg("R3 held high cleared", A_PEND, 32'h0);
      @(negedge clk);
      check_reg("R3 held high stays clear", A_PEND, 32'h0);
      check_out("R3 no output", 4'd0);
      req_in[6] = 1'b0;
      @(negedge clk);
      req_in[6] = 1'b1;
      @(negedge clk);
      check_reg("R3 second edge sets", A_PEND, 32'h0000_0040);
      check_out("R3 output", 4'd6);
      req_in = '0;
      wr(A_CLEAR, 32'hFFFE);

      // R2 contrast: level mode re-captures a held request
      wr(A_SHAPE, 32'h0);
      req_in[6] = 1'b1;
      @(negedge clk);
      wr(A_CLEAR, 32'h0000_0040);
      @(negedge clk);
      check_reg("R2 level held re-pends", A_PEND, 32'h0000_0040);
      req_in = '0;
      wr(A_CLEAR, 32'hFFFE);
      check_reg("R2 final clear", A_PEND, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule